// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block models the command interface of a word-wide NOR flash that uses a bottom-boot sector layout. It watches bus write cycles, recognises the unlock-and-command handshakes, and runs word program, whole-array erase and multi-sector erase with an accumulation window. It also supports pausing an erase so that other sectors can be read or programmed. The embedded algorithms are abstracted into cycle counters whose lengths are parameters. The storage is a small behavioural array: each of the 19 sectors is backed by four 16-bit cells, and the two lowest word-address bits select the cell.

A write is taken on the cycle where write-enable is seen high after having been low, with chip-enable low and output-enable high. Read data is combinational from the address while chip-enable and output-enable are both low. While an operation is running, reads return a status byte instead of array data.

Top module: `flashCmdSeq`

## Requirements
- R1: After reset is released, the block is in array-read mode and every cell reads 0xFFFF with no command written; `dataOutEn` is high only while `ceN` and `oeN` are both low and `rstN` is high.
- R2: The sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 followed by a data write at a word address stores old AND new in the addressed cell PROG_CYCLES cycles later, then returns to array-read mode. Only bits [10:0] of the address are compared and only bits [7:0] of the data are compared for command cycles.
- R3: While busy, reads return a status word with bits [15:8] zero and bit 6 inverting after every completed read (an `oeN` rise with `ceN` low). Bit 7 is the inverse of bit 7 of the data being programmed during a program, and 0 during erase. Bit 3 is 0 during the sector accumulation window and 1 once erasing has begun. All other bits are 0.
- R4: Any command cycle that does not match the expected address/data returns the block to array-read mode, and a later data write has no effect.
- R5: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 erases every sector to 0xFFFF. Every write during this erase, including suspend, is ignored.
- R6: The same five-cycle prefix followed by 0x30 at any address in a sector erases exactly that sector.
- R7: Each further 0x30 write during the window adds the addressed sector, in any order, and restarts the WINDOW_CYCLES-cycle window. Erasing begins only when the window expires.
- R8: Any write other than 0x30 or 0xB0 during the window drops the queued sectors and returns to array-read mode, with nothing erased.
- R9: Once erasing has begun, every write other than 0xB0 is ignored, including further 0x30 writes.
- R10: Before each sector is erased, all its cells are cleared to 0x0000, and only then set to 0xFFFF. A reset after this clearing leaves the cells at 0x0000.
- R11: 0xB0 during a sector erase pauses it. Reads of queued sectors then return 0x0080, reads of other sectors return array data, programs to other sectors work, and programs to queued sectors are dropped. A 0x30 write resumes the erase, which then completes.
- R12: Driving `rstN` low aborts any program or erase, forces `dataOutEn` low, ignores all bus cycles while low, and leaves the block in array-read mode.
- R13: Sectors decode from the 19-bit word address as follows. 0x00000-0x01FFF is sector 0, 0x02000-0x02FFF is 1, 0x03000-0x03FFF is 2, 0x04000-0x07FFF is 3, and each 0x8000-word block k>=1 is sector 3+k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; bus strobes are sampled on its rising edge |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low; a write completes on its rise |
| oeN | input | 1 | Output enable, active low |
| addr | input | 19 | Word address |
| wdata | input | 16 | Write data |
| dataOut | output | 16 | Array data or status word |
| dataOutEn | output | 1 | High when `dataOut` would be driven onto the bus |

## Verification
A wrong sequencer state shows up at the next read: a block stuck busy returns a status word where array data is expected, and a block that wrongly drops back to reading shows array data where the status toggle bit should be moving. Queue or engine faults show only after the erase finishes, as sectors holding the wrong contents. The bench therefore reads back every cell after each operation, so a fault is caught within one operation's duration plus a 76-read sweep. Window restart and the clearing that precedes erase are timed against known cycle offsets, so an off-by-window fault or a skipped clearing step changes a specific read.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;
  localparam int NUM_SECT = 19;
  localparam int SECT_W   = $clog2(NUM_SECT);
  localparam int ADDR_W   = 19;
  localparam int DATA_W   = 16;
  localparam int CELL_AW  = 2;
  localparam int CELLS    = 1 << CELL_AW;
  localparam int MEM_N    = NUM_SECT * CELLS;

  localparam logic [7:0]  CMD_KEY1    = 8'hAA;
  localparam logic [7:0]  CMD_KEY2    = 8'h55;
  localparam logic [10:0] KEY1_ADDR   = 11'h555;
  localparam logic [10:0] KEY2_ADDR   = 11'h2AA;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_SETUP   = 8'h80;
  localparam logic [7:0]  CMD_CHIP    = 8'h10;
  localparam logic [7:0]  CMD_SECT    = 8'h30;
  localparam logic [7:0]  CMD_SUSPEND = 8'hB0;
  localparam logic [7:0]  CMD_RESUME  = 8'h30;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_PROG_DATA, ST_ER_SETUP,
    ST_ER_UNL1, ST_ER_UNL2, ST_PROG_BUSY, ST_SECT_WIN, ST_ERASING
  } cmdState_e;

  typedef struct packed {
    logic                progWr;
    logic [SECT_W-1:0]   progSect;
    logic [CELL_AW-1:0]  progCell;
    logic [DATA_W-1:0]   progData;
    logic                zeroWr;
    logic                fillWr;
    logic [SECT_W-1:0]   engSect;
    logic [CELL_AW-1:0]  engCell;
    logic                showStatus;
    logic [7:0]          statusByte;
  } dpStrobe_t;

  function automatic logic [SECT_W-1:0] sectorOf(input logic [ADDR_W-1:0] a);
    if (a[18:15] != 4'd0)       return SECT_W'(a[18:15]) + SECT_W'(3);
    else if (a[14])             return SECT_W'(3);
    else if (a[13:12] == 2'b11) return SECT_W'(2);
    else if (a[13])             return SECT_W'(1);
    else                        return SECT_W'(0);
  endfunction

  function automatic logic [SECT_W-1:0] lowestSet(input logic [NUM_SECT-1:0] m);
    logic [SECT_W-1:0] r;
    r = '0;
    for (int i = NUM_SECT - 1; i >= 0; i--)
      if (m[i]) r = SECT_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
#(
  parameter int PROG_CYCLES   = 1000,
  parameter int ERASE_CYCLES  = 40000,
  parameter int WINDOW_CYCLES = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output dpStrobe_t         strobe
);
  localparam int PCNT_W = $clog2(PROG_CYCLES + 1);
  localparam int ECNT_W = $clog2(((ERASE_CYCLES > WINDOW_CYCLES) ? ERASE_CYCLES : WINDOW_CYCLES) + 1);
  localparam logic [PCNT_W-1:0]  PROG_LAST  = PCNT_W'(PROG_CYCLES - 1);
  localparam logic [ECNT_W-1:0]  ERASE_LAST = ECNT_W'(ERASE_CYCLES - 1);
  localparam logic [ECNT_W-1:0]  WIN_LAST   = ECNT_W'(WINDOW_CYCLES - 1);
  localparam logic [CELL_AW-1:0] CELL_LAST  = '1;

  cmdState_e           state;
  logic                suspended, chipMode, engPre, toggle, weQ, oeQ;
  logic [NUM_SECT-1:0] eraseMask;
  logic [SECT_W-1:0]   curSect, progSect;
  logic [CELL_AW-1:0]  cellCnt, progCell;
  logic [ECNT_W-1:0]   engCnt;
  logic [PCNT_W-1:0]   progCnt;
  logic [DATA_W-1:0]   progData;

  logic writeEv, readEnd, isKey1, isKey2, at555, suspendHit;
  logic [7:0]          cmdByte;
  logic [SECT_W-1:0]   wrSect;
  logic [NUM_SECT-1:0] wrBit, remaining;

  assign writeEv    = !weQ && weN && !ceN && oeN;
  assign readEnd    = !oeQ && oeN && !ceN;
  assign cmdByte    = wdata[7:0];
  assign at555      = addr[10:0] == KEY1_ADDR;
  assign isKey1     = at555 && cmdByte == CMD_KEY1;
  assign isKey2     = addr[10:0] == KEY2_ADDR && cmdByte == CMD_KEY2;
  assign wrSect     = sectorOf(addr);
  assign wrBit      = NUM_SECT'(1) << wrSect;
  assign remaining  = eraseMask & ~(NUM_SECT'(1) << curSect);
  assign suspendHit = writeEv && cmdByte == CMD_SUSPEND && !chipMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_READ;  suspended <= 1'b0; chipMode <= 1'b0; engPre <= 1'b1;
      toggle <= 1'b0;    weQ <= 1'b1;       oeQ <= 1'b1;      eraseMask <= '0;
      curSect <= '0;     cellCnt <= '0;     engCnt <= '0;     progCnt <= '0;
      progSect <= '0;    progCell <= '0;    progData <= '0;
    end else begin
      weQ <= weN;
      oeQ <= oeN;
      if (readEnd) toggle <= ~toggle;
      case (state)
        ST_READ: if (writeEv) begin
          if (isKey1) state <= ST_UNL1;
          else if (suspended && cmdByte == CMD_RESUME) begin
            state <= ST_ERASING; suspended <= 1'b0;
          end
        end
        ST_UNL1: if (writeEv) state <= isKey2 ? ST_UNL2 : ST_READ;
        ST_UNL2: if (writeEv) begin
          if (at555 && cmdByte == CMD_PROG) state <= ST_PROG_DATA;
          else if (at555 && cmdByte == CMD_SETUP && !suspended) state <= ST_ER_SETUP;
          else state <= ST_READ;
        end
        ST_PROG_DATA: if (writeEv) begin
          progSect <= wrSect; progCell <= addr[CELL_AW-1:0];
          progData <= wdata;  progCnt <= '0;
          state <= (suspended && eraseMask[wrSect]) ? ST_READ : ST_PROG_BUSY;
        end
        ST_ER_SETUP: if (writeEv) state <= isKey1 ? ST_ER_UNL1 : ST_READ;
        ST_ER_UNL1:  if (writeEv) state <= isKey2 ? ST_ER_UNL2 : ST_READ;
        ST_ER_UNL2: if (writeEv) begin
          if (at555 && cmdByte == CMD_CHIP) begin
            eraseMask <= '1; chipMode <= 1'b1; curSect <= '0; cellCnt <= '0;
            engPre <= 1'b1;  engCnt <= '0;     state <= ST_ERASING;
          end else if (cmdByte == CMD_SECT) begin
            eraseMask <= wrBit; engCnt <= '0; state <= ST_SECT_WIN;
          end else state <= ST_READ;
        end
        ST_PROG_BUSY:
          if (progCnt == PROG_LAST) state <= ST_READ;
          else progCnt <= progCnt + 1'b1;
        ST_SECT_WIN:
          if (writeEv && cmdByte == CMD_SECT) begin
            eraseMask <= eraseMask | wrBit; engCnt <= '0;
          end else if (writeEv && cmdByte == CMD_SUSPEND) begin
            curSect <= lowestSet(eraseMask); engPre <= 1'b1; cellCnt <= '0;
            engCnt <= '0; suspended <= 1'b1; state <= ST_READ;
          end else if (writeEv) begin
            eraseMask <= '0; state <= ST_READ;
          end else if (engCnt == WIN_LAST) begin
            curSect <= lowestSet(eraseMask); engPre <= 1'b1; cellCnt <= '0;
            engCnt <= '0; state <= ST_ERASING;
          end else engCnt <= engCnt + 1'b1;
        ST_ERASING:
          if (suspendHit) begin
            suspended <= 1'b1; state <= ST_READ;
          end else if (engPre) begin
            if (cellCnt == CELL_LAST) begin engPre <= 1'b0; engCnt <= '0; end
            cellCnt <= cellCnt + 1'b1;
          end else if (engCnt == ERASE_LAST) begin
            eraseMask <= remaining;
            if (remaining == '0) begin
              state <= ST_READ; chipMode <= 1'b0;
            end else begin
              curSect <= lowestSet(remaining); engPre <= 1'b1; cellCnt <= '0;
            end
          end else engCnt <= engCnt + 1'b1;
        default: state <= ST_READ;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.progWr     = state == ST_PROG_BUSY && progCnt == PROG_LAST;
    strobe.progSect   = progSect;
    strobe.progCell   = progCell;
    strobe.progData   = progData;
    strobe.zeroWr     = state == ST_ERASING && engPre && !suspendHit;
    strobe.fillWr     = state == ST_ERASING && !engPre && engCnt == ERASE_LAST && !suspendHit;
    strobe.engSect    = curSect;
    strobe.engCell    = cellCnt;
    case (state)
      ST_PROG_BUSY: begin strobe.showStatus = 1'b1; strobe.statusByte = {~progData[7], toggle, 6'b0}; end
      ST_SECT_WIN:  begin strobe.showStatus = 1'b1; strobe.statusByte = {1'b0, toggle, 6'b0}; end
      ST_ERASING:   begin strobe.showStatus = 1'b1; strobe.statusByte = {1'b0, toggle, 2'b0, 1'b1, 3'b0}; end
      default: if (suspended && eraseMask[wrSect]) begin
        strobe.showStatus = 1'b1; strobe.statusByte = 8'h80;
      end
    endcase
  end

  assert_read_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> state == ST_READ && !suspended);
  assert_prog_returns_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progWr |=> state == ST_READ);
  assert_chip_no_pause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASING && chipMode) |=> !suspended && (state == ST_ERASING || state == ST_READ));
  assert_engine_on_queued_R6: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ERASING |-> eraseMask[curSect]);
  assert_window_only_adds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SECT_WIN && $past(state) == ST_SECT_WIN) |-> (eraseMask & $past(eraseMask)) == $past(eraseMask));
endmodule

// File: rtl/flashCmdData.sv
module flashCmdData
  import flashCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int IDX_W = SECT_W + CELL_AW;
  localparam logic [CELL_AW-1:0] CELL_LAST = '1;

  logic [DATA_W-1:0] mem [MEM_N];
  logic [IDX_W-1:0]  rdIdx;

  initial for (int i = 0; i < MEM_N; i++) mem[i] = '1;

  always_ff @(posedge clk) begin
    if (strobe.progWr)
      mem[{strobe.progSect, strobe.progCell}] <= mem[{strobe.progSect, strobe.progCell}] & strobe.progData;
    else if (strobe.zeroWr)
      mem[{strobe.engSect, strobe.engCell}] <= '0;
    else if (strobe.fillWr)
      for (int c = 0; c < CELLS; c++) mem[{strobe.engSect, CELL_AW'(c)}] <= '1;
  end

  assign rdIdx     = {sectorOf(addr), addr[CELL_AW-1:0]};
  assign dataOutEn = rstN && !ceN && !oeN;
  always_comb begin
    if (!dataOutEn)             dataOut = '0;
    else if (strobe.showStatus) dataOut = {8'h00, strobe.statusByte};
    else                        dataOut = mem[rdIdx];
  end

  assert_cleared_before_erase_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWr |-> mem[{strobe.engSect, CELL_LAST}] == '0);
  assert_erase_sets_ones_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWr |=> mem[{$past(strobe.engSect), {CELL_AW{1'b0}}}] == '1);
endmodule

// File: rtl/flashCmdSeq.sv
module flashCmdSeq
  import flashCmdPkg::*;
#(
  parameter int PROG_CYCLES   = 1000,
  parameter int ERASE_CYCLES  = 40000,
  parameter int WINDOW_CYCLES = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  dpStrobe_t strobe;

  flashCmdCtrl #(
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wdata(wdata), .strobe(strobe)
  );

  flashCmdData data_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .addr(addr),
    .strobe(strobe), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: tb/flashCmdSeq_tb_top.sv
module flashCmdSeq_tb_top;
  localparam int PROG = 12;
  localparam int ERAS = 20;
  localparam int WIN  = 30;
  localparam int PER_SECT = 4 + ERAS;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [18:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] dataOut;
  logic dataOutEn;
  logic [15:0] expMem [19][4];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flashCmdSeq #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERAS), .WINDOW_CYCLES(WIN)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wdata(wdata), .dataOut(dataOut), .dataOutEn(dataOutEn));

  function automatic logic [18:0] base(input int s);
    if (s == 0) return 19'h00000;
    if (s == 1) return 19'h02000;
    if (s == 2) return 19'h03000;
    if (s == 3) return 19'h04000;
    return 19'((s - 3) * 32'h8000);
  endfunction

  function automatic logic [18:0] lastAddr(input int s);
    if (s == 18) return 19'h7FFFF;
    return base(s + 1) - 19'd1;
  endfunction

  function automatic logic [15:0] pat(input int s, input int c);
    return 16'hC3A5 ^ 16'(s << 5) ^ 16'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; ceN = 1'b0; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask

  task automatic busRead(input logic [18:0] a, output logic [15:0] d, output logic en);
    @(negedge clk); addr = a; ceN = 1'b0; oeN = 1'b0; #1; d = dataOut; en = dataOutEn;
    @(negedge clk); oeN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask

  task automatic unlock();
    busWrite(19'h555, 16'h00AA);
    busWrite(19'h2AA, 16'h0055);
  endtask

  task automatic progStart(input int s, input int c, input logic [15:0] d);
    unlock();
    busWrite(19'h555, 16'h00A0);
    busWrite(base(s) + 19'(c), d);
  endtask

  task automatic erasePrefix();
    unlock();
    busWrite(19'h555, 16'h0080);
    unlock();
  endtask

  task automatic checkCell(input int s, input int c, input string req);
    logic [15:0] d; logic en;
    busRead(base(s) + 19'(c), d, en);
    chk(en && d == expMem[s][c], req, d, expMem[s][c]);
  endtask

  task automatic checkAll(input string req);
    for (int s = 0; s < 19; s++)
      for (int c = 0; c < 4; c++) checkCell(s, c, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, d2; logic en;
    for (int s = 0; s < 19; s++) for (int c = 0; c < 4; c++) expMem[s][c] = 16'hFFFF;
    waitCyc(3);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; #1;
    chk(!dataOutEn, "R1 outputs off in reset", 16'(dataOutEn), 16'h0);
    @(negedge clk); ceN = 1'b1; oeN = 1'b1; rstN = 1'b1;
    waitCyc(2);
    #1 chk(!dataOutEn, "R1 outputs off when deselected", 16'(dataOutEn), 16'h0);
    checkAll("R1 erased array after reset, R13 map");

    // R2: program every cell of every sector
    for (int s = 0; s < 19; s++)
      for (int c = 0; c < 4; c++) begin
        progStart(s, c, pat(s, c));
        waitCyc(PROG + 3);
        expMem[s][c] = pat(s, c);
      end
    checkAll("R2 program sweep");
    progStart(3, 1, 16'h0F0F); waitCyc(PROG + 3);
    expMem[3][1] &= 16'h0F0F;
    checkCell(3, 1, "R2 program only clears bits");

    // R3: status during a program
    progStart(0, 0, 16'h0012);
    busRead(base(0), d, en);
    chk((d & 16'hFFBF) == 16'h0080, "R3 program status", d & 16'hFFBF, 16'h0080);
    busRead(base(0), d2, en);
    chk((d ^ d2) == 16'h0040, "R3 toggle bit", d ^ d2, 16'h0040);
    waitCyc(PROG);
    expMem[0][0] &= 16'h0012;
    checkCell(0, 0, "R2 returns to array read");

    // R4: mismatched unlock address, then mismatch at the second key stage
    busWrite(19'h555, 16'h00AA); busWrite(19'h2AB, 16'h0055);
    busWrite(19'h555, 16'h00A0); busWrite(base(1), 16'h0000);
    waitCyc(PROG + 3);
    checkCell(1, 0, "R4 bad key address ignored");
    erasePrefix(); busWrite(19'h555, 16'h00A0); busWrite(base(1) + 19'd1, 16'h0000);
    waitCyc(WIN + PER_SECT + 5);
    checkCell(1, 1, "R4 bad erase command ignored");

    // R7: window restart and out-of-order accumulation
    erasePrefix(); busWrite(base(12) + 19'd3, 16'h0030);
    waitCyc(15);
    busWrite(base(4) + 19'd2, 16'h0030);
    waitCyc(WIN - 6);
    busRead(base(0), d, en);
    chk((d & 16'hFFBF) == 16'h0000, "R7 window restarted / R3 window status", d & 16'hFFBF, 16'h0000);
    waitCyc(5);
    busRead(base(0), d, en);
    chk((d & 16'hFFBF) == 16'h0008, "R7 erase begins / R3 erase status", d & 16'hFFBF, 16'h0008);
    busRead(base(0), d2, en);
    chk((d ^ d2) == 16'h0040, "R3 toggle during erase", d ^ d2, 16'h0040);
    busWrite(base(10), 16'h0030);
    waitCyc(2 * PER_SECT + 20);
    for (int c = 0; c < 4; c++) begin expMem[12][c] = 16'hFFFF; expMem[4][c] = 16'hFFFF; end
    checkAll("R7 two queued sectors erased, R9 late command ignored");

    // R8: abort in the window
    erasePrefix(); busWrite(base(6), 16'h0030);
    waitCyc(5);
    busWrite(base(6), 16'h00F0);
    busRead(base(6), d, en);
    chk(d == expMem[6][0], "R8 abort to array read", d, expMem[6][0]);
    waitCyc(WIN + PER_SECT + 5);
    checkCell(6, 1, "R8 nothing erased");

    // R11: pause, access other sectors, resume
    erasePrefix(); busWrite(base(8), 16'h0030); busWrite(base(9), 16'h0030);
    waitCyc(WIN + 6);
    busWrite(19'h0, 16'h00B0);
    busRead(base(8), d, en);
    chk(d == 16'h0080, "R11 paused queued sector", d, 16'h0080);
    busRead(base(9) + 19'd1, d, en);
    chk(d == 16'h0080, "R11 paused queued sector 2", d, 16'h0080);
    checkCell(2, 0, "R11 other sector readable");
    progStart(2, 1, 16'h00F0); waitCyc(PROG + 3);
    expMem[2][1] &= 16'h00F0;
    checkCell(2, 1, "R11 program while paused");
    progStart(9, 2, 16'h0000);
    checkCell(2, 0, "R11 program to queued sector dropped");
    busWrite(19'h0, 16'h0030);
    busRead(base(0), d, en);
    chk((d & 16'hFFBF) == 16'h0008, "R11 resumed erase busy", d & 16'hFFBF, 16'h0008);
    waitCyc(2 * PER_SECT + 20);
    for (int c = 0; c < 4; c++) begin expMem[8][c] = 16'hFFFF; expMem[9][c] = 16'hFFFF; end
    checkAll("R11 resumed erase completes");

    // R10: reset after the clearing step
    erasePrefix(); busWrite(base(5), 16'h0030);
    waitCyc(WIN + 10);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int c = 0; c < 4; c++) expMem[5][c] = 16'h0000;
    for (int c = 0; c < 4; c++) checkCell(5, c, "R10 cleared before erase");
    checkCell(6, 0, "R12 erase aborted, neighbour intact");

    // R12: reset during program and bus cycles during reset
    progStart(7, 1, 16'h0000);
    waitCyc(3);
    @(negedge clk); rstN = 1'b0; ceN = 1'b0; oeN = 1'b0; #1;
    chk(!dataOutEn, "R12 outputs off during reset", 16'(dataOutEn), 16'h0);
    @(negedge clk); oeN = 1'b1; ceN = 1'b1;
    unlock(); busWrite(19'h555, 16'h00A0);
    @(negedge clk); rstN = 1'b1;
    busWrite(base(7) + 19'd2, 16'h0000);
    waitCyc(PROG + 3);
    checkCell(7, 1, "R12 program aborted");
    checkCell(7, 2, "R12 writes ignored during reset");

    // R6 / R13: erase each sector through its last address
    for (int s = 0; s < 19; s++) begin
      erasePrefix(); busWrite(lastAddr(s), 16'h0030);
      waitCyc(WIN + PER_SECT + 10);
      for (int c = 0; c < 4; c++) expMem[s][c] = 16'hFFFF;
      checkAll("R6 single sector erase, R13 sector decode");
    end

    // R5: chip erase ignores suspend
    progStart(0, 2, 16'h1234); waitCyc(PROG + 3);
    progStart(18, 3, 16'h0000); waitCyc(PROG + 3);
    erasePrefix(); busWrite(19'h555, 16'h0010);
    waitCyc(3);
    busWrite(19'h0, 16'h00B0);
    busRead(base(0), d, en);
    chk((d & 16'hFFBF) == 16'h0008, "R5 suspend ignored in chip erase", d & 16'hFFBF, 16'h0008);
    waitCyc(19 * PER_SECT + 20);
    for (int s = 0; s < 19; s++) for (int c = 0; c < 4; c++) expMem[s][c] = 16'hFFFF;
    checkAll("R5 chip erase");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule